// File: doc/BRIEF.md
# Multi-mode quadrature position counter

This block turns the two signals of an incremental encoder, A and B, into a 32-bit position count. A two-bit source field picks one of four counting modes. The first is full-resolution quadrature, where every edge of either input counts. The second is pulse-with-direction. The last two are count-up-only and count-down-only, both clocked by A. In the two single-input modes, a control bit selects whether only rising edges of A count or both edges do.

Both inputs pass through a synchroniser before edge detection, so they may be fully asynchronous to the block clock. The count wraps within a programmable ceiling, and each wrap raises a sticky flag. Software reaches everything through a small word-addressed register port. Each flag has its own interrupt enable, and a single interrupt line reports any flag that is both set and enabled.

Register addresses:

| Address | Register |
|---|---|
| 0 | position |
| 1 | ceiling |
| 2 | decode control |
| 3 | main control |
| 4 | interrupt enable |
| 5 | flags (read only) |
| 6 | flag clear (write only, reads as zero) |

A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `qpos_counter`

## Requirements
- R1: After reset the position is 0, the ceiling is all ones, decode control, main control, interrupt enable and flags are 0, and `irq` is low.
- R2: With source field decode[15:14]=00 (quadrature), each single-input change of A or B moves the count by one. When A leads B (AB 00→10→11→01→00), the count goes up; the reverse order counts down.
- R3: In quadrature mode, a sample in which A and B both change produces no count.
- R4: With source field 01 (pulse/direction), only a rising edge of A counts. The count goes up when B is 1 and down when B is 0; edges of B and falling edges of A do nothing.
- R5: With source field 10 (up), A counts up and B is ignored. Decode bit 11 at 0 counts rising edges of A only; at 1 it counts both edges of A.
- R6: With source field 11 (down), A counts down under the same edge rule as R5, and B is ignored.
- R7: While main control bit 3 is 0, input edges leave the count unchanged.
- R8: A write to the position register loads the value when it is not above the ceiling. A write above the ceiling is refused and the count stays unchanged.
- R9: Counting up from the ceiling wraps to 0 and sets flag bit 6 (overflow). Counting down from 0 wraps to the ceiling and sets flag bit 5 (underflow).
- R10: `irq` is high exactly when a flag among bits 6 and 5 is set and the enable at the same bit position is 1. Writing 1 to a bit of the clear register clears that flag; flags are sticky otherwise.
- R11: Flag bit 0 is set when `irq` rises and is cleared by writing 1 to clear bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder input A, asynchronous |
| enc_b | input | 1 | Encoder input B, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Quadrature stimulus is run in both phase orders, so a decoder with its direction sense inverted is caught. Samples where both inputs flip together show whether illegal Gray transitions are rejected. In pulse/direction mode, B is toggled between pulses without pulsing A, so counting on B edges or on falling A edges shows up in the count. In the up and down modes, the same A pulse train is applied with the both-edges bit clear and then set; the doubling of the step tells the two edge selections apart. Wraps are driven at both the ceiling and zero, with the interrupt enables toggled, to separate flag setting from interrupt masking.

// File: rtl/qpos_pkg.sv
package qpos_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned CTL_W  = 16;

  localparam logic [ADDR_W-1:0] A_POS   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CEIL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DEC   = 3'd2;
  localparam logic [ADDR_W-1:0] A_MAIN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IEN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLR   = 3'd6;

  localparam int unsigned B_SRC_HI  = 15;
  localparam int unsigned B_SRC_LO  = 14;
  localparam int unsigned B_BOTH    = 11;
  localparam int unsigned B_RUN     = 3;
  localparam int unsigned B_OVF     = 6;
  localparam int unsigned B_UNF     = 5;
  localparam int unsigned B_GLOBAL  = 0;

  typedef enum logic [1:0] {
    SRC_QUAD = 2'b00,
    SRC_PDIR = 2'b01,
    SRC_UP   = 2'b10,
    SRC_DOWN = 2'b11
  } src_mode_t;
endpackage

// File: rtl/qpos_sync_edge.sv
module qpos_sync_edge #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] chain_q [STAGES];
  logic [W-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] d_in;
      if (s == 0) begin : g_first
        assign d_in = raw_in;
      end else begin : g_next
        assign d_in = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= d_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign cur  = chain_q[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/qpos_step_decode.sv
module qpos_step_decode
  import qpos_pkg::*;
(
  input  src_mode_t  mode,
  input  logic       both_edges,
  input  logic [1:0] cur,    // {A, B}
  input  logic [1:0] prev,   // {A, B}
  output logic       step,
  output logic       up
);
  logic a_rise, a_fall, a_chg, b_chg;

  always_comb begin
    a_chg  = cur[1] ^ prev[1];
    b_chg  = cur[0] ^ prev[0];
    a_rise = cur[1] & ~prev[1];
    a_fall = ~cur[1] & prev[1];
    step   = 1'b0;
    up     = 1'b1;
    unique case (mode)
      SRC_QUAD: begin
        step = a_chg ^ b_chg;          // exactly one input moved
        up   = cur[1] ^ prev[0];       // A leading B counts up
      end
      SRC_PDIR: begin
        step = a_rise;
        up   = cur[0];
      end
      SRC_UP: begin
        step = a_rise | (both_edges & a_fall);
        up   = 1'b1;
      end
      SRC_DOWN: begin
        step = a_rise | (both_edges & a_fall);
        up   = 1'b0;
      end
      default: begin
        step = 1'b0;
        up   = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/qpos_position.sv
module qpos_position #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             step,
  input  logic             up,
  input  logic             ld_req,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] ceil_val,
  output logic [CNT_W-1:0] count,
  output logic             ovf_p,
  output logic             unf_p
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    ovf_p  = 1'b0;
    unf_p  = 1'b0;
    if (ld_req) begin
      // a write to the position always wins the cycle; refused if above ceiling
      if (ld_val <= ceil_val) begin
        cnt_d  = ld_val;
        cnt_en = 1'b1;
      end
    end else if (run_en && step) begin
      cnt_en = 1'b1;
      if (up) begin
        if (cnt_q >= ceil_val) begin
          cnt_d = '0;
          ovf_p = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = ceil_val;
          unf_p = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/qpos_irq_flags.sv
module qpos_irq_flags
  import qpos_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ovf_p,
  input  logic             unf_p,
  input  logic             ovf_en,
  input  logic             unf_en,
  input  logic             clr_wr,
  input  logic [CTL_W-1:0] clr_val,
  output logic [CTL_W-1:0] flags,
  output logic             irq
);
  logic ovf_q, unf_q, glb_q, irq_q;
  logic ovf_d, unf_d, glb_d;
  logic irq_c;

  always_comb begin
    irq_c = (ovf_q & ovf_en) | (unf_q & unf_en);
    ovf_d = ovf_p | (ovf_q & ~(clr_wr & clr_val[B_OVF]));
    unf_d = unf_p | (unf_q & ~(clr_wr & clr_val[B_UNF]));
    glb_d = (irq_c & ~irq_q) | (glb_q & ~(clr_wr & clr_val[B_GLOBAL]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
      glb_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      glb_q <= glb_d;
      irq_q <= irq_c;
    end
  end

  always_comb begin
    flags           = '0;
    flags[B_OVF]    = ovf_q;
    flags[B_UNF]    = unf_q;
    flags[B_GLOBAL] = glb_q;
  end

  assign irq = irq_c;
endmodule

// File: rtl/qpos_counter.sv
module qpos_counter
  import qpos_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int unsigned PAD_W = CNT_W - CTL_W;

  logic [CNT_W-1:0] ceil_q;
  logic [CTL_W-1:0] dec_q, main_q, ien_q;
  logic             wr_ceil, wr_dec, wr_main, wr_ien, wr_clr, wr_pos;

  logic [1:0]       enc_cur, enc_prev;
  logic             step, up, ovf_p, unf_p, run_en;
  logic [CNT_W-1:0] count;
  logic [CTL_W-1:0] flags;
  src_mode_t        mode;

  always_comb begin
    wr_pos  = bus_wr && (bus_addr == A_POS);
    wr_ceil = bus_wr && (bus_addr == A_CEIL);
    wr_dec  = bus_wr && (bus_addr == A_DEC);
    wr_main = bus_wr && (bus_addr == A_MAIN);
    wr_ien  = bus_wr && (bus_addr == A_IEN);
    wr_clr  = bus_wr && (bus_addr == A_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ceil_q <= '1;
    else if (wr_ceil) ceil_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dec_q <= '0;
    else if (wr_dec) dec_q <= bus_wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       main_q <= '0;
    else if (wr_main) main_q <= bus_wdata[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= '0;
    else if (wr_ien) ien_q <= bus_wdata[CTL_W-1:0];
  end

  assign mode   = src_mode_t'(dec_q[B_SRC_HI:B_SRC_LO]);
  assign run_en = main_q[B_RUN];

  qpos_sync_edge #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in ({enc_a, enc_b}),
    .cur    (enc_cur),
    .prev   (enc_prev)
  );

  qpos_step_decode u_dec (
    .mode       (mode),
    .both_edges (dec_q[B_BOTH]),
    .cur        (enc_cur),
    .prev       (enc_prev),
    .step       (step),
    .up         (up)
  );

  qpos_position #(.CNT_W(CNT_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .step     (step),
    .up       (up),
    .ld_req   (wr_pos),
    .ld_val   (bus_wdata),
    .ceil_val (ceil_q),
    .count    (count),
    .ovf_p    (ovf_p),
    .unf_p    (unf_p)
  );

  qpos_irq_flags u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf_p   (ovf_p),
    .unf_p   (unf_p),
    .ovf_en  (ien_q[B_OVF]),
    .unf_en  (ien_q[B_UNF]),
    .clr_wr  (wr_clr),
    .clr_val (bus_wdata[CTL_W-1:0]),
    .flags   (flags),
    .irq     (irq)
  );

  always_comb begin
    unique case (bus_addr)
      A_POS:   bus_rdata = count;
      A_CEIL:  bus_rdata = ceil_q;
      A_DEC:   bus_rdata = {{PAD_W{1'b0}}, dec_q};
      A_MAIN:  bus_rdata = {{PAD_W{1'b0}}, main_q};
      A_IEN:   bus_rdata = {{PAD_W{1'b0}}, ien_q};
      A_FLAG:  bus_rdata = {{PAD_W{1'b0}}, flags};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/qpos_checker.sv
module qpos_checker
  import qpos_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [CNT_W-1:0]  count,
  input logic [CNT_W-1:0]  ceil_q,
  input logic              run_en,
  input logic              ovf_p,
  input logic              unf_p,
  input logic [CTL_W-1:0]  flags,
  input logic [CTL_W-1:0]  ien_q,
  input logic              irq
);
  // R7: disabled counter with no load holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !(bus_wr && bus_addr == A_POS)) |=> $stable(count));

  // R8: refused load leaves the count unchanged
  a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_POS && bus_wdata > ceil_q) |=> $stable(count));

  // R9: overflow wraps to zero and raises its flag
  a_r9_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_p |=> (count == '0) && flags[B_OVF]);

  // R9: underflow wraps to the ceiling and raises its flag
  a_r9_unf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    unf_p |=> (count == $past(ceil_q)) && flags[B_UNF]);

  // R9: never overflow and underflow in the same cycle
  a_r9_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_p, unf_p}));

  // R10: with both enables off the interrupt stays low
  a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien_q[B_OVF] && !ien_q[B_UNF]) |-> !irq);

  // R11: a rising interrupt sets the global flag
  a_r11_global: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |=> flags[B_GLOBAL]);
endmodule

bind qpos_counter qpos_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .count     (count),
  .ceil_q    (ceil_q),
  .run_en    (run_en),
  .ovf_p     (ovf_p),
  .unf_p     (unf_p),
  .flags     (flags),
  .ien_q     (ien_q),
  .irq       (irq)
);

// File: tb/sim_qpos_counter.sv
`timescale 1ns/1ps
module sim_qpos_counter;
  logic        clk;
  logic        rst_n;
  logic        enc_a, enc_b;
  logic        bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  qpos_counter u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 3'd0;
  endtask

  task automatic set_ab(input logic a, input logic b);
    @(negedge clk);
    enc_a = a; enc_b = b;
    settle(4);
  endtask

  task automatic pulse_a(input int n);
    for (int i = 0; i < n; i++) begin
      set_ab(1'b1, enc_b);
      set_ab(1'b0, enc_b);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check("R1 position", v, 32'd0);
    rd(3'd1, v); check("R1 ceiling", v, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R1 decode", v, 32'd0);
    rd(3'd3, v); check("R1 main", v, 32'd0);
    rd(3'd5, v); check("R1 flags", v, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_quad();
    logic [31:0] v;
    wr(3'd2, 32'h0000); wr(3'd3, 32'h0008); wr(3'd0, 32'd10);
    set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
    rd(3'd0, v); check("R2 quad forward", v, 32'd14);
    set_ab(0, 1); set_ab(1, 1); set_ab(1, 0); set_ab(0, 0);
    rd(3'd0, v); check("R2 quad reverse", v, 32'd10);
  endtask

  task automatic t_illegal();
    logic [31:0] v;
    set_ab(1, 1);
    rd(3'd0, v); check("R3 both change up", v, 32'd10);
    set_ab(0, 0);
    rd(3'd0, v); check("R3 both change down", v, 32'd10);
  endtask

  task automatic t_pdir();
    logic [31:0] v;
    wr(3'h2, 32'h4000);
    set_ab(0, 1);
    pulse_a(3);
    rd(3'd0, v); check("R4 pdir up", v, 32'd13);
    set_ab(0, 0); set_ab(0, 1); set_ab(0, 0);
    rd(3'd0, v); check("R4 B edges ignored", v, 32'd13);
    pulse_a(2);
    rd(3'd0, v); check("R4 pdir down", v, 32'd11);
  endtask

  task automatic t_updown();
    logic [31:0] v;
    wr(3'd2, 32'h8000);
    pulse_a(2);
    rd(3'd0, v); check("R5 up rising only", v, 32'd13);
    set_ab(0, 1); set_ab(0, 0);
    rd(3'd0, v); check("R5 B ignored", v, 32'd13);
    wr(3'd2, 32'h8800);
    pulse_a(2);
    rd(3'd0, v); check("R5 up both edges", v, 32'd17);
    wr(3'd2, 32'hC000);
    pulse_a(3);
    rd(3'd0, v); check("R6 down rising only", v, 32'd14);
    wr(3'd2, 32'hC800);
    pulse_a(1);
    rd(3'd0, v); check("R6 down both edges", v, 32'd12);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(3'd3, 32'h0000);
    pulse_a(3);
    rd(3'd0, v); check("R7 disabled holds", v, 32'd12);
    wr(3'd3, 32'h0008);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(3'd1, 32'd100);
    wr(3'd0, 32'd50);
    rd(3'd0, v); check("R8 load accepted", v, 32'd50);
    wr(3'd0, 32'd101);
    rd(3'd0, v); check("R8 load refused", v, 32'd50);
    wr(3'd0, 32'd100);
    rd(3'd0, v); check("R8 load at ceiling", v, 32'd100);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(3'd2, 32'h8000);
    pulse_a(1);
    rd(3'd0, v); check("R9 overflow wrap", v, 32'd0);
    rd(3'd5, v); check("R9 overflow flag", v, 32'h40);
    check("R10 masked irq", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'h40);
    settle(2);
    check("R10 irq enabled", {31'd0, irq}, 32'd1);
    rd(3'd5, v); check("R11 global set", v, 32'h41);
    wr(3'd6, 32'h41);
    settle(1);
    rd(3'd5, v); check("R10 flags cleared", v, 32'h0);
    check("R10 irq low after clear", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'hC000);
    pulse_a(1);
    rd(3'd0, v); check("R9 underflow wrap", v, 32'd100);
    rd(3'd5, v); check("R9 underflow flag", v, 32'h20);
    check("R10 unf masked", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'h60);
    settle(2);
    check("R10 unf irq", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h20);
    settle(1);
    rd(3'd5, v); check("R11 global sticky", v, 32'h01);
    wr(3'd6, 32'h01);
    rd(3'd5, v); check("R11 global cleared", v, 32'h00);
  endtask

  initial begin
    rst_n = 1'b0; enc_a = 1'b0; enc_b = 1'b0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    settle(3);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_quad();
    t_illegal();
    t_pdir();
    t_updown();
    t_enable();
    t_load();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule